// File: doc/BRIEF.md
# Piecewise-Linear Sensor Code to Temperature Converter

This block turns a 12-bit thermal sensor code into a signed temperature in micro-degrees Celsius. It holds a fixed calibration table of code/temperature pairs at 5-degree spacing from -40 to 125 degrees. For each accepted code it walks that table one entry per cycle until it finds the first entry whose code is at or above the input. It then either returns that entry's temperature directly or interpolates linearly from the entry below it, using a truncating integer division.

A code is offered on a valid/ready input. `in_ready` is high only while the converter is idle. A code is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_valid` is ignored at all other times. The result comes back as a one-cycle `out_valid` pulse with `out_temp` and `out_ok`. The output has no back-pressure, so the consumer must take the result in the cycle it is shown. A code outside the calibrated window yields a sentinel instead of a temperature. A parameter selects one of two calibrations. The second one stores each code as 4096 minus a listed value, so that codes still rise with temperature.

Top module: `pwl_temp_conv`

## Requirements
- R1: `in_ready` is 1 exactly while the block is idle. A code is accepted on an edge with `in_valid`=1 and `in_ready`=1. While busy, `in_ready` is 0, `in_valid` and `in_code` have no effect, and the result belongs to the code that was accepted.
- R2: Each accepted code produces exactly one `out_valid` pulse, one cycle long. `out_temp` and `out_ok` are meaningful in that cycle.
- R3: With the default calibration, a code below 401 or above 686 gives `out_ok`=0 and `out_temp`=32'h00000FFF.
- R4: With the default calibration, the table has index 0 at code 0 (-40 degrees). Indices 1..34 hold codes 402,410,419,427,436,444,453,461,470,478,487,496,504,513,521,530,538,547,555,564,573,581,590,599,607,616,624,633,642,650,659,668,677,685, at -40+5*(index-1) degrees. Index 35 is code 4095 at 125 degrees. A code equal to an entry's code returns that entry's temperature × 1,000,000 exactly, with `out_ok`=1.
- R5: Any other in-range code picks U, the first entry from index 1 upward whose code exceeds it, and L, the entry just below U. It returns T(L) + floor((T(U)−T(L))·(code−C(L)) / (C(U)−C(L))) in micro-degrees, with `out_ok`=1.
- R6: The two end segments are flat. With the default calibration, codes 401 and 686 give -40,000,000 and 125,000,000.
- R7: With `CAL_SEL`=1, each entry code at indices 1..34 is 4096 minus 3800,3792,3783,3774,3765,3756,3747,3737,3728,3718,3708,3698,3688,3678,3667,3656,3645,3634,3623,3611,3600,3588,3575,3563,3550,3537,3524,3510,3496,3482,3467,3452,3437,3421. Index 0 is code 1 and index 35 is code 4096. The valid window is 295..676, and R3 to R6 apply with these codes.
- R8: After reset, `in_ready`=1 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Code offered |
| in_ready | output | 1 | Converter idle, code can be taken |
| in_code | input | 12 | Sensor code |
| out_valid | output | 1 | One-cycle result strobe |
| out_ok | output | 1 | 1 when `out_temp` is a temperature, 0 for the sentinel |
| out_temp | output | 32 | Signed temperature in micro-degrees Celsius, or the sentinel |

## Verification
Both calibrations are swept over every code from just below their valid window to just above it. This covers exact table hits, every interpolated segment with its truncation, both flat end segments and the codes one step outside the window. Extreme codes 0 and 4095 confirm that the sentinel is not confused with a segment lookup. A separate run keeps `in_valid` high with a different code while a slow interpolation is in flight. It shows that the ready gating drops those offers and that no second result appears.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  localparam int CODE_W   = 12;
  localparam int TAB_W    = CODE_W + 1;
  localparam int TEMP_W   = 32;
  localparam int N_PTS    = 34;
  localparam int ENTRIES  = N_PTS + 2;
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int T_MIN_DEG  = -40;
  localparam int T_STEP_DEG = 5;
  localparam int UNIT       = 1000000;
  localparam int INV_BASE   = 4096;

  localparam logic [TEMP_W-1:0] SENTINEL = TEMP_W'(32'h0000_0FFF);

  typedef logic [TAB_W-1:0]           tab_code_t;
  typedef logic signed [TEMP_W-1:0]   temp_t;
  typedef logic [IDX_W-1:0]           idx_t;
  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_DIV, ST_DONE} conv_state_t;

  // Rising calibration, codes for the interior points.
  localparam int RISE_TAB [N_PTS] = '{
    402, 410, 419, 427, 436, 444, 453, 461, 470, 478, 487, 496,
    504, 513, 521, 530, 538, 547, 555, 564, 573, 581, 590, 599,
    607, 616, 624, 633, 642, 650, 659, 668, 677, 685};

  // Mirrored calibration, values stored as INV_BASE minus these.
  localparam int MIRROR_TAB [N_PTS] = '{
    3800, 3792, 3783, 3774, 3765, 3756, 3747, 3737, 3728, 3718, 3708, 3698,
    3688, 3678, 3667, 3656, 3645, 3634, 3623, 3611, 3600, 3588, 3575, 3563,
    3550, 3537, 3524, 3510, 3496, 3482, 3467, 3452, 3437, 3421};

  function automatic tab_code_t cal_code(input int sel, input int idx);
    int v;
    if (idx <= 0)                v = (sel != 0) ? 1 : 0;
    else if (idx >= ENTRIES - 1) v = (sel != 0) ? INV_BASE : INV_BASE - 1;
    else if (sel != 0)           v = INV_BASE - MIRROR_TAB[idx-1];
    else                         v = RISE_TAB[idx-1];
    return tab_code_t'(v);
  endfunction

  function automatic temp_t cal_temp(input int idx);
    int deg;
    if (idx <= 0)                deg = T_MIN_DEG;
    else if (idx >= ENTRIES - 1) deg = T_MIN_DEG + T_STEP_DEG * (N_PTS - 1);
    else                         deg = T_MIN_DEG + T_STEP_DEG * (idx - 1);
    return temp_t'(deg * UNIT);
  endfunction
endpackage

// File: rtl/pwl_cal_rom.sv
module pwl_cal_rom
  import pwl_pkg::*;
#(
  parameter int CAL_SEL = 0
) (
  input  idx_t      idx,
  output tab_code_t hi_code,
  output tab_code_t lo_code,
  output temp_t     hi_temp,
  output temp_t     lo_temp
);
  tab_code_t code_tab [ENTRIES];
  temp_t     temp_tab [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    if (CAL_SEL == 0) begin : g_rise
      assign code_tab[g] = cal_code(0, g);
    end else begin : g_mirror
      assign code_tab[g] = cal_code(1, g);
    end
    assign temp_tab[g] = cal_temp(g);
  end

  idx_t hi_a, lo_a;
  always_comb begin
    hi_a = (idx > idx_t'(ENTRIES - 1)) ? idx_t'(ENTRIES - 1) : idx;
    lo_a = (hi_a == '0) ? '0 : hi_a - idx_t'(1);
    hi_code = code_tab[hi_a];
    lo_code = code_tab[lo_a];
    hi_temp = temp_tab[hi_a];
    lo_temp = temp_tab[lo_a];
  end
endmodule

// File: rtl/pwl_range_gate.sv
module pwl_range_gate
  import pwl_pkg::*;
#(
  parameter int CAL_SEL = 0
) (
  input  logic [CODE_W-1:0] code,
  output logic              in_range
);
  localparam tab_code_t WIN_LO = cal_code(CAL_SEL, 1) - tab_code_t'(1);
  localparam tab_code_t WIN_HI = cal_code(CAL_SEL, N_PTS) + tab_code_t'(1);

  tab_code_t code_x;
  assign code_x   = {1'b0, code};
  assign in_range = (code_x >= WIN_LO) && (code_x <= WIN_HI);
endmodule

// File: rtl/pwl_restoring_div.sv
module pwl_restoring_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_r;
  logic [DEN_W-1:0] rem_r, den_r;
  logic [CNT_W-1:0] cnt_r;
  logic             busy_r;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign shifted = {rem_r, q_r[NUM_W-1]};
  assign fits    = shifted >= {1'b0, den_r};
  assign trial   = shifted - {1'b0, den_r};
  assign quo     = q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      rem_r  <= '0;
      den_r  <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy_r <= 1'b1;
        q_r    <= num;
        rem_r  <= '0;
        den_r  <= den;
        cnt_r  <= CNT_W'(NUM_W);
      end else if (busy_r) begin
        rem_r <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
        q_r   <= {q_r[NUM_W-2:0], fits};
        cnt_r <= cnt_r - CNT_W'(1);
        if (cnt_r == CNT_W'(1)) begin
          busy_r <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R5: partial remainder always stays below the divisor
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r |-> (rem_r < den_r));
  // R1: a new division never lands on one in flight
  p_start_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_r);
endmodule

// File: rtl/pwl_temp_conv.sv
module pwl_temp_conv
  import pwl_pkg::*;
#(
  parameter int CAL_SEL = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [11:0]              in_code,
  output logic                     out_valid,
  output logic                     out_ok,
  output logic signed [31:0]       out_temp
);
  localparam temp_t T_LO = cal_temp(0);
  localparam temp_t T_HI = cal_temp(ENTRIES - 1);

  conv_state_t st;
  tab_code_t   code_q;
  idx_t        idx;
  temp_t       base_q, res_q;
  logic        ok_q;

  tab_code_t   hi_code, lo_code;
  temp_t       hi_temp, lo_temp;
  logic        code_ok;
  logic        hit, exact, div_start, div_done;
  logic [TEMP_W-1:0] step_u, num_u, quo_u;
  tab_code_t   diff_u, den_u;

  pwl_cal_rom #(.CAL_SEL(CAL_SEL)) u_rom (
    .idx(idx), .hi_code(hi_code), .lo_code(lo_code),
    .hi_temp(hi_temp), .lo_temp(lo_temp));

  pwl_range_gate #(.CAL_SEL(CAL_SEL)) u_gate (
    .code(in_code), .in_range(code_ok));

  assign hit       = hi_code >= code_q;
  assign exact     = hi_code == code_q;
  assign step_u    = hi_temp - lo_temp;
  assign diff_u    = code_q - lo_code;
  assign den_u     = hi_code - lo_code;
  assign num_u     = step_u * TEMP_W'(diff_u);
  assign div_start = (st == ST_SEARCH) && hit && !exact;

  pwl_restoring_div #(.NUM_W(TEMP_W), .DEN_W(TAB_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(num_u),
    .den(den_u), .done(div_done), .quo(quo_u));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      code_q <= '0;
      idx    <= '0;
      base_q <= '0;
      res_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (in_valid) begin
          code_q <= {1'b0, in_code};
          if (code_ok) begin
            idx <= idx_t'(1);
            st  <= ST_SEARCH;
          end else begin
            res_q <= SENTINEL;
            ok_q  <= 1'b0;
            st    <= ST_DONE;
          end
        end
        ST_SEARCH: begin
          if (hit) begin
            if (exact) begin
              res_q <= hi_temp;
              ok_q  <= 1'b1;
              st    <= ST_DONE;
            end else begin
              base_q <= lo_temp;
              st     <= ST_DIV;
            end
          end else begin
            idx <= idx + idx_t'(1);
          end
        end
        ST_DIV: if (div_done) begin
          res_q <= base_q + temp_t'(quo_u);
          ok_q  <= 1'b1;
          st    <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_DONE);
  assign out_ok    = ok_q;
  assign out_temp  = res_q;

  // R2: the result strobe never lasts two cycles
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R3: a rejected code reports only the sentinel
  p_sentinel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ok) |-> (out_temp == SENTINEL));
  // R1: the captured code is frozen while not ready
  p_code_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(code_q));
  // R5: a valid temperature lies within the calibrated span
  p_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ok) |-> (out_temp >= T_LO && out_temp <= T_HI));
  // R4: the search index stays inside the table
  p_idx_in_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEARCH) |-> (idx >= idx_t'(1) && idx <= idx_t'(ENTRIES - 1)));
endmodule

// File: tb/pwl_temp_conv_tb_top.sv
`timescale 1ns/1ps
module pwl_temp_conv_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic v0, v1, r0, r1, ov0, ov1, ok0, ok1;
  logic [11:0] c0, c1;
  logic signed [31:0] t0, t1;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int rise_tab [34] = '{402,410,419,427,436,444,453,461,470,478,487,496,
    504,513,521,530,538,547,555,564,573,581,590,599,607,616,624,633,642,
    650,659,668,677,685};
  int mirror_tab [34] = '{3800,3792,3783,3774,3765,3756,3747,3737,3728,
    3718,3708,3698,3688,3678,3667,3656,3645,3634,3623,3611,3600,3588,3575,
    3563,3550,3537,3524,3510,3496,3482,3467,3452,3437,3421};

  pwl_temp_conv #(.CAL_SEL(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_ready(r0), .in_code(c0),
    .out_valid(ov0), .out_ok(ok0), .out_temp(t0));

  pwl_temp_conv #(.CAL_SEL(1)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_ready(r1), .in_code(c1),
    .out_valid(ov1), .out_ok(ok1), .out_temp(t1));

  function automatic int tb_code(int sel, int i);
    if (i == 0) return (sel != 0) ? 1 : 0;
    if (i == 35) return (sel != 0) ? 4096 : 4095;
    return (sel != 0) ? 4096 - mirror_tab[i-1] : rise_tab[i-1];
  endfunction

  function automatic longint tb_temp(int i);
    if (i == 0) return -40000000;
    if (i == 35) return 125000000;
    return longint'(-40 + 5 * (i - 1)) * 1000000;
  endfunction

  task automatic expect_of(input int sel, input int code, output bit eok,
                           output longint et, output string tag);
    int lo, hi;
    lo = tb_code(sel, 1) - 1;
    hi = tb_code(sel, 34) + 1;
    eok = 1'b0; et = 4095; tag = (sel != 0) ? "R7" : "R3";
    if (code >= lo && code <= hi) begin
      eok = 1'b1;
      for (int i = 1; i < 36; i++) begin
        if (tb_code(sel, i) >= code) begin
          if (tb_code(sel, i) == code) begin
            et = tb_temp(i); tag = "R4";
          end else begin
            et = tb_temp(i-1) + ((tb_temp(i) - tb_temp(i-1)) *
                 longint'(code - tb_code(sel, i-1))) /
                 longint'(tb_code(sel, i) - tb_code(sel, i-1));
            tag = (i == 1 || i == 35) ? "R6" : "R5";
          end
          break;
        end
      end
      if (sel != 0) tag = "R7";
    end
  endtask

  task automatic check(input bit cond, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_result(input int sel, output bit seen);
    int n = 0;
    while (!((sel != 0) ? ov1 : ov0) && n < 300) begin
      @(negedge clk); n++;
    end
    seen = (sel != 0) ? ov1 : ov0;
  endtask

  task automatic run_one(input int sel, input int code);
    bit eok, seen;
    longint et, at;
    string tag;
    expect_of(sel, code, eok, et, tag);
    @(negedge clk);
    if (sel != 0) begin v1 = 1'b1; c1 = 12'(code); end
    else begin v0 = 1'b1; c0 = 12'(code); end
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
    wait_result(sel, seen);
    check(seen, "R2", "result strobe seen", longint'(seen), 1);
    if (seen) begin
      at = (sel != 0) ? longint'(t1) : longint'(t0);
      check(((sel != 0) ? ok1 : ok0) == eok, tag, $sformatf("ok code=%0d", code),
            longint'((sel != 0) ? ok1 : ok0), longint'(eok));
      check(at == et, tag, $sformatf("temp code=%0d", code), at, et);
      @(negedge clk);
      check(((sel != 0) ? ov1 : ov0) == 1'b0, "R2", "strobe one cycle",
            longint'((sel != 0) ? ov1 : ov0), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    rst_n = 1'b0; v0 = 1'b0; v1 = 1'b0; c0 = '0; c1 = '0;
    repeat (3) @(negedge clk);
    check(r0 && r1, "R8", "ready in reset", longint'({r0, r1}), 3);
    check(!ov0 && !ov1, "R8", "no strobe in reset", longint'({ov0, ov1}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(r0 && r1 && !ov0 && !ov1, "R8", "idle after reset",
          longint'({r0, r1, ov0, ov1}), 12);

    // corner codes, default calibration
    foreach (rise_tab[k]) if (k < 1) begin end
    run_one(0, 0);    run_one(0, 4095); run_one(0, 400); run_one(0, 687);
    run_one(0, 401);  run_one(0, 686);  run_one(0, 402); run_one(0, 470);
    run_one(0, 471);  run_one(0, 685);
    for (int c = 380; c <= 700; c++) run_one(0, c);

    // corner codes, mirrored calibration
    run_one(1, 0);   run_one(1, 4095); run_one(1, 294); run_one(1, 677);
    run_one(1, 295); run_one(1, 676);  run_one(1, 296);
    for (int c = 270; c <= 690; c++) run_one(1, c);

    // R1: offers while busy are dropped
    @(negedge clk);
    v0 = 1'b1; c0 = 12'd471;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      v0 = 1'b1; c0 = 12'd600;
      check(r0 == 1'b0, "R1", "not ready while busy", longint'(r0), 0);
      @(negedge clk);
    end
    v0 = 1'b0;
    wait_result(0, seen);
    check(seen, "R1", "busy result seen", longint'(seen), 1);
    check(t0 == 32'sd625000, "R1", "result of accepted code", longint'(t0), 625000);
    @(negedge clk);
    seen = 1'b0;
    for (int k = 0; k < 80; k++) begin
      if (ov0) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R1", "no result for dropped offer", longint'(seen), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule